// File: doc/BRIEF.md
# Reversible-Cell Selectable Logic Function Generator

This block evaluates eight two-operand Boolean functions of a pair of input bits in parallel and routes one of them to a single result bit under a three-bit function code. Every gate in both the function bank and the routing tree is one bijective three-input, three-output cell. Whatever a cell computes that the datapath does not consume is brought out on a garbage bus. No information is thrown away inside a cell. A single two-input fan-out cell that copies one operand and produces the XOR of both completes the bank.

The cell passes its first input straight through on P. On Q it gives the complement of the XOR of its other two inputs. On R it steers its second input when the first is 0 and its third input when the first is 1, so one cell is a 2:1 selector. The routing tree chains its select copies along each level. Each level therefore leaves only one select copy as garbage. The tree depth is a parameter, and its cell and garbage counts are checked at elaboration. The whole block is combinational, and all outputs follow the inputs with no clock.

Top module: `rlg_fngen`

## Requirements
- R1: The cell maps (a,b,c) to p = a, q = NOT(b XOR c), r = (a ? c : b). For the inputs 000 through 111 its (p,q,r) outputs are 010, 000, 001, 011, 110, 101, 100, 111.
- R2: The cell is reversible: its eight input vectors yield eight distinct output vectors.
- R3: func_o carries, by bit index: 0 = A AND B, 1 = A NOR B, 2 = A OR B, 3 = A NAND B, 4 = A XNOR B, 5 = A XOR B, 6 = A, 7 = NOT B.
- R4: y_o equals func_o[sel_i], with sel_i read as an unsigned binary index. For example, 3'b011 selects NAND and 3'b111 selects NOT B.
- R5: garb_o is 25 bits wide. Bits 0 to 14 come from the function bank and bits 15 to 24 from the routing tree. Bits 22, 23 and 24 carry the leftover select copies of sel_i[2], sel_i[1] and sel_i[0].
- R6: A routing tree of depth n uses 2^n - 1 cells and exposes 2^n + n - 1 garbage bits; for n = 3 that is 7 cells and 10 bits.
- R7: All outputs are combinational. A new input vector is reflected on y_o, func_o and garb_o within the same clock cycle in which it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 1 | Operand A |
| b_i | input | 1 | Operand B |
| sel_i | input | 3 | Function code, binary index into func_o |
| y_o | output | 1 | Selected function result |
| func_o | output | 8 | All eight function results in parallel |
| garb_o | output | 25 | Unconsumed cell outputs (bank low, tree high) |

## Verification
All 32 combinations of the two operands and the function code are applied one per cycle. The four operand pairs separate each function from its complement and from its neighbours in the code order. Sweeping every code for fixed operands shows that the tree resolves each select bit at the correct level and does not swap inputs inside a pair. The cell is also driven alone through its eight input vectors. This confirms its truth table and shows that no two outputs collide.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

    localparam int SEL_W     = 3;
    localparam int FN_CNT    = 1 << SEL_W;
    localparam int BANK_GARB = 15;
    localparam int TREE_GARB = (1 << SEL_W) + SEL_W - 1;
    localparam int GARB_W    = BANK_GARB + TREE_GARB;

    typedef enum logic [SEL_W-1:0] {
        FN_AND  = 3'd0,
        FN_NOR  = 3'd1,
        FN_OR   = 3'd2,
        FN_NAND = 3'd3,
        FN_XNOR = 3'd4,
        FN_XOR  = 3'd5,
        FN_CPYA = 3'd6,
        FN_NOTB = 3'd7
    } fn_e;

    // Cell count of a selector tree, summed level by level.
    function automatic int tree_cells(input int depth);
        int total = 0;
        for (int l = 0; l < depth; l++) total += (1 << l);
        return total;
    endfunction

endpackage

// File: rtl/rev_cell.sv
module rev_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic p_o,
    output logic q_o,
    output logic r_o
);
    assign p_o = a_i;
    assign q_o = ~(b_i ^ c_i);
    assign r_o = a_i ? c_i : b_i;
endmodule

// File: rtl/rev_fanout.sv
module rev_fanout (
    input  logic x_i,
    input  logic y_i,
    output logic x_o,
    output logic xy_o
);
    assign x_o  = x_i;
    assign xy_o = x_i ^ y_i;
endmodule

// File: rtl/rev_fn_bank.sv
module rev_fn_bank
    import rlg_pkg::*;
(
    input  logic                 a_i,
    input  logic                 b_i,
    output logic [FN_CNT-1:0]    fn_o,
    output logic [BANK_GARB-1:0] garb_o
);
    logic tie0, tie1;
    logic nb;
    logic unused_r;

    assign tie0 = 1'b0;
    assign tie1 = 1'b1;

    // Inverter cell: (0, B, 0) -> q = NOT B
    rev_cell u_not  (.a_i(tie0), .b_i(b_i),  .c_i(tie0), .p_o(garb_o[12]), .q_o(nb),         .r_o(garb_o[13]));
    // (A, 0, B) -> r = A AND B
    rev_cell u_and  (.a_i(a_i),  .b_i(tie0), .c_i(b_i),  .p_o(garb_o[0]),  .q_o(garb_o[1]),  .r_o(fn_o[FN_AND]));
    // (A, ~B, 0) -> r = A NOR B
    rev_cell u_nor  (.a_i(a_i),  .b_i(nb),   .c_i(tie0), .p_o(garb_o[2]),  .q_o(garb_o[3]),  .r_o(fn_o[FN_NOR]));
    // (A, B, 1) -> r = A OR B
    rev_cell u_or   (.a_i(a_i),  .b_i(b_i),  .c_i(tie1), .p_o(garb_o[4]),  .q_o(garb_o[5]),  .r_o(fn_o[FN_OR]));
    // (A, 1, ~B) -> r = A NAND B
    rev_cell u_nand (.a_i(a_i),  .b_i(tie1), .c_i(nb),   .p_o(garb_o[6]),  .q_o(garb_o[7]),  .r_o(fn_o[FN_NAND]));
    // (0, A, B) -> q = A XNOR B
    rev_cell u_xnor (.a_i(tie0), .b_i(a_i),  .c_i(b_i),  .p_o(garb_o[8]),  .q_o(fn_o[FN_XNOR]), .r_o(unused_r));
    // (0, A, 0) -> r = A
    rev_cell u_copy (.a_i(tie0), .b_i(a_i),  .c_i(tie0), .p_o(garb_o[10]), .q_o(garb_o[11]), .r_o(fn_o[FN_CPYA]));
    // Fan-out cell: second output is A XOR B
    rev_fanout u_fo (.x_i(a_i), .y_i(b_i), .x_o(garb_o[14]), .xy_o(fn_o[FN_XOR]));

    assign garb_o[9]     = unused_r;
    assign fn_o[FN_NOTB] = nb;
endmodule

// File: rtl/rev_mux_tree.sv
module rev_mux_tree
    import rlg_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int N      = 1 << DEPTH,
    localparam int CELLS  = N - 1,
    localparam int GOUT_W = N + DEPTH - 1
) (
    input  logic [DEPTH-1:0]  sel_i,
    input  logic [N-1:0]      din_i,
    output logic              dout_o,
    output logic [GOUT_W-1:0] garb_o
);
    // Elaboration check of the closed-form counts against a level sum.
    if (tree_cells(DEPTH) != CELLS || GOUT_W != tree_cells(DEPTH) + DEPTH) begin : g_count_bad
        $error("selector tree cell or garbage count mismatch");
    end

    // Level 0 is the root and uses the MSB; the leaf level uses sel_i[0].
    for (genvar l = 0; l < DEPTH; l++) begin : lvl
        for (genvar j = 0; j < (1 << l); j++) begin : node
            logic a_s, b_s, c_s, p, q, r;

            if (j == 0) begin : g_head
                assign a_s = sel_i[DEPTH-1-l];
            end else begin : g_chain
                assign a_s = lvl[l].node[j-1].p;
            end

            if (l == DEPTH - 1) begin : g_leaf
                assign b_s = din_i[2*j];
                assign c_s = din_i[2*j+1];
            end else begin : g_inner
                assign b_s = lvl[l+1].node[2*j].r;
                assign c_s = lvl[l+1].node[2*j+1].r;
            end

            rev_cell u_cell (.a_i(a_s), .b_i(b_s), .c_i(c_s), .p_o(p), .q_o(q), .r_o(r));

            assign garb_o[(1 << l) - 1 + j] = q;
            if (j == (1 << l) - 1) begin : g_tail
                assign garb_o[CELLS + l] = p;
            end
        end
    end

    assign dout_o = lvl[0].node[0].r;
endmodule

// File: rtl/rlg_fngen.sv
module rlg_fngen
    import rlg_pkg::*;
(
    input  logic              a_i,
    input  logic              b_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              y_o,
    output logic [FN_CNT-1:0] func_o,
    output logic [GARB_W-1:0] garb_o
);
    logic [BANK_GARB-1:0] bank_garb;
    logic [TREE_GARB-1:0] tree_garb;

    rev_fn_bank u_bank (
        .a_i    (a_i),
        .b_i    (b_i),
        .fn_o   (func_o),
        .garb_o (bank_garb)
    );

    rev_mux_tree #(.DEPTH(SEL_W)) u_tree (
        .sel_i  (sel_i),
        .din_i  (func_o),
        .dout_o (y_o),
        .garb_o (tree_garb)
    );

    assign garb_o = {tree_garb, bank_garb};
endmodule

// File: rtl/rlg_fngen_chk.sv
module rlg_fngen_chk
    import rlg_pkg::*;
(
    input logic              a_i,
    input logic              b_i,
    input logic [SEL_W-1:0]  sel_i,
    input logic              y_o,
    input logic [FN_CNT-1:0] func_o,
    input logic [GARB_W-1:0] garb_o
);
    always_comb begin
        AST_ROUTE_MATCH: assert (y_o == func_o[sel_i]) else $error("route mismatch"); // R4
        AST_AND_OR_PAIR: assert ((func_o[0] == (a_i & b_i)) && (func_o[2] == (a_i | b_i))) else $error("and/or"); // R3
        AST_COMPL_PAIRS: assert ((func_o[3] == ~func_o[0]) && (func_o[1] == ~func_o[2]) && (func_o[4] == ~func_o[5])) else $error("complement pairs"); // R3
        AST_PASS_FUNCS: assert ((func_o[6] == a_i) && (func_o[7] == ~b_i)) else $error("copy/not"); // R3
        AST_SEL_COPIES: assert (garb_o[GARB_W-1] == sel_i[0] && garb_o[GARB_W-2] == sel_i[1] && garb_o[GARB_W-3] == sel_i[2]) else $error("select copies"); // R5
    end
endmodule

bind rlg_fngen rlg_fngen_chk u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .sel_i  (sel_i),
    .y_o    (y_o),
    .func_o (func_o),
    .garb_o (garb_o)
);

// File: tb/rlg_fngen_test.sv
module rlg_fngen_test;
    import rlg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a, b;
    logic [2:0] sel;
    logic y;
    logic [7:0] func;
    logic [24:0] garb;
    logic ca, cb, cc, cp, cq, cr;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rlg_fngen uut (.a_i(a), .b_i(b), .sel_i(sel), .y_o(y), .func_o(func), .garb_o(garb));
    rev_cell  u_cell (.a_i(ca), .b_i(cb), .c_i(cc), .p_o(cp), .q_o(cq), .r_o(cr));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_bank(input logic ra, input logic rb);
        logic [7:0] f;
        f[0] = ra && rb;
        f[1] = !(ra || rb);
        f[2] = ra || rb;
        f[3] = !(ra && rb);
        f[4] = (ra == rb);
        f[5] = (ra != rb);
        f[6] = ra;
        f[7] = !rb;
        return f;
    endfunction

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] tt [8];
        logic [7:0] seen;
        tt[0] = 3'b010; tt[1] = 3'b000; tt[2] = 3'b001; tt[3] = 3'b011;
        tt[4] = 3'b110; tt[5] = 3'b101; tt[6] = 3'b100; tt[7] = 3'b111;
        a = 0; b = 0; sel = 0; ca = 0; cb = 0; cc = 0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R6: width of the garbage bus for depth 3
        check("R6 garbage width", $bits(garb), 25);

        // R1 and R2: standalone cell sweep
        seen = '0;
        for (int v = 0; v < 8; v++) begin
            @(posedge clk);
            {ca, cb, cc} = 3'(v);
            @(negedge clk);
            check("R1 cell truth table", {cp, cq, cr}, tt[v]);
            if (seen[{cp, cq, cr}]) check("R2 cell output repeated", {cp, cq, cr}, 32'hFFFF);
            seen[{cp, cq, cr}] = 1'b1;
        end
        check("R2 distinct cell outputs", seen, 8'hFF);

        // R3 R4 R5 R7: full sweep, result checked in the cycle of application
        for (int v = 0; v < 32; v++) begin
            logic [7:0] f;
            @(posedge clk);
            {a, b, sel} = 5'(v);
            f = ref_bank(a, b);
            @(negedge clk);
            check("R3 function bank", func, f);
            check("R4 R7 selected output", y, f[sel]);
            check("R5 select copies", garb[24:22], {sel[0], sel[1], sel[2]});
        end

        // R7: operand change with fixed code updates the output in the same cycle
        @(posedge clk);
        a = 1; b = 0; sel = FN_XOR;
        @(negedge clk);
        check("R7 same-cycle xor", y, 1);
        @(posedge clk);
        b = 1;
        @(negedge clk);
        check("R7 same-cycle xor update", y, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule